// File: doc/BRIEF.md
# Block Address Translation Matcher

This block keeps a small set of block-translation entries in two banks, one searched by instruction fetches and one by loads and stores. Every entry is a pair of 32-bit registers. The upper register holds a block base, a block-length code and two validity flags, one for each privilege state. The lower register holds the real base and a protection code. On each cycle the effective address is compared against every entry of the selected bank at once. A priority encoder picks the lowest-numbered matching entry.

The block-length code removes base bits from the compare, which makes the block larger. The real address is built from two parts: the real-base bits that take part in the compare, and the effective-address bits that do not. It is then truncated to a 4 KiB page. The hit flag, real page address and permission mask are registered, so they appear one clock after the lookup inputs.

Entries are loaded through a simple write port that carries a bank select, an entry index, an upper/lower select and a data word. Fault reporting and page-table walks are handled by other blocks, which consume the outputs of this one.

Top module: `blk_xlate_match`

## Requirements
- R1: An access kind of 2'b10 (fetch) searches the instruction bank. Kinds 2'b00 (load), 2'b01 (store) and 2'b11 search the data bank.
- R2: Upper-register bit 0 is the user-state valid flag and bit 1 is the supervisor-state valid flag. An entry whose flag for the current privilege state (`user_mode`) is clear never matches.
- R3: The block-length code in upper bits [12:2] is placed at address bits [27:17] and removes those bits from the compare. The compare covers address bits [31:17] only.
- R4: An entry matches only when the effective address, masked as in R3, equals upper bits [31:17].
- R5: On a hit, the real address takes the compared bit positions from the lower register and all other positions from the effective address. Bits [11:0] are then forced to zero.
- R6: Lower bits [1:0] hold the protection code. The permission output uses bit 0 for read, bit 1 for write and bit 2 for execute. Code 0 gives 3'b000, codes 1 and 3 give 3'b101, and code 2 gives 3'b111.
- R7: When several entries of the selected bank match, the lowest-numbered one supplies the result.
- R8: With no matching entry, `res_hit` is 0 and both `res_raddr` and `res_perm` are 0.
- R9: Results appear on the outputs at the first rising clock edge after the lookup inputs are presented. They hold until the next edge.
- R10: A write with `wr_en` high updates the register chosen by `wr_ibank`, `wr_idx` and `wr_lower`. It takes effect for lookups presented from the following cycle, and no other register changes.
- R11: While reset is asserted, all entries are cleared, so none is valid, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_ibank | input | 1 | 1 writes the instruction bank, 0 writes the data bank |
| wr_lower | input | 1 | 1 writes the lower register, 0 writes the upper register |
| wr_idx | input | 2 | Entry index to write |
| wr_data | input | 32 | Write data |
| ea | input | 32 | Effective address to translate |
| acc_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| user_mode | input | 1 | 1 for user state, 0 for supervisor state |
| res_hit | output | 1 | Registered hit flag |
| res_raddr | output | 32 | Registered real page address |
| res_perm | output | 3 | Registered permission mask {exec, write, read} |

## Verification
The assertions assume that reset is asserted from time zero, so that the entry registers and the result register hold known values before the first unreset edge. They also assume the write port and the lookup inputs change only away from the rising clock edge. The bench drives every input on the falling edge and holds reset for several cycles at the start. It places block bases only inside the compared field, writes complete register words, and only uses protection codes and block lengths that fit the documented fields.

// File: rtl/bat_pkg.sv
package bat_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_kind_e;

   localparam int PERM_W = 3;
   localparam int PERM_RD = 0;
   localparam int PERM_WR = 1;
   localparam int PERM_EX = 2;

   localparam int BANK_DATA = 0;
   localparam int BANK_INST = 1;
   localparam int N_BANKS   = 2;

   function automatic logic [PERM_W-1:0] prot_to_perm(input logic [1:0] code);
      logic [PERM_W-1:0] p;
      p = '0;
      if (code != 2'd0) begin
         p[PERM_RD] = 1'b1;
         p[PERM_EX] = 1'b1;
         p[PERM_WR] = (code == 2'd2);
      end
      return p;
   endfunction

endpackage

// File: rtl/bat_bank.sv
module bat_bank #(
   parameter int N_ENT  = 4,
   parameter int ADDR_W = 32,
   localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic                          wr_lower,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [ADDR_W-1:0]             wr_data,
   output logic [N_ENT-1:0][ADDR_W-1:0]  upper_q,
   output logic [N_ENT-1:0][ADDR_W-1:0]  lower_q
);

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      logic sel_e;
      assign sel_e = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            upper_q[e] <= '0;
            lower_q[e] <= '0;
         end else if (sel_e) begin
            if (wr_lower) lower_q[e] <= wr_data;
            else          upper_q[e] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/bat_entry_cmp.sv
module bat_entry_cmp
   import bat_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int BLK_LSB   = 17,
   parameter int BL_W      = 11,
   parameter int PAGE_BITS = 12
) (
   input  logic [ADDR_W-1:0] upper,
   input  logic [ADDR_W-1:0] lower,
   input  logic [ADDR_W-1:0] ea,
   input  logic              user_mode,
   output logic              match,
   output logic [ADDR_W-1:0] raddr,
   output logic [PERM_W-1:0] perm
);

   localparam logic [ADDR_W-1:0] BASE_MASK = {ADDR_W{1'b1}} << BLK_LSB;
   localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << PAGE_BITS;
   localparam int BL_LO = 2;
   localparam int BL_HI = BL_LO + BL_W - 1;

   logic              ok_priv;
   logic [BL_W-1:0]   len_code;
   logic [ADDR_W-1:0] len_spread;
   logic [ADDR_W-1:0] cmp_mask;
   logic [ADDR_W-1:0] merged;

   always_comb begin
      ok_priv    = user_mode ? upper[0] : upper[1];
      len_code   = upper[BL_HI:BL_LO];
      len_spread = ADDR_W'(len_code) << BLK_LSB;
      cmp_mask   = BASE_MASK & ~len_spread;
      match      = ok_priv && ((ea & cmp_mask) == (upper & BASE_MASK));
      merged     = (lower & cmp_mask) | (ea & ~cmp_mask);
      raddr      = merged & PAGE_MASK;
      perm       = prot_to_perm(lower[1:0]);
   end

endmodule

// File: rtl/bat_prio.sv
module bat_prio #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);

   always_comb begin
      logic taken;
      taken = 1'b0;
      grant = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !taken) begin
            grant[i] = 1'b1;
            taken    = 1'b1;
         end
      end
      any = taken;
   end

endmodule

// File: rtl/blk_xlate_match.sv
module blk_xlate_match
   import bat_pkg::*;
#(
   parameter int N_ENT     = 4,
   parameter int ADDR_W    = 32,
   parameter int BLK_LSB   = 17,
   parameter int BL_W      = 11,
   parameter int PAGE_BITS = 12,
   localparam int IDX_W    = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_ibank,
   input  logic              wr_lower,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] ea,
   input  logic [1:0]        acc_kind,
   input  logic              user_mode,
   output logic              res_hit,
   output logic [ADDR_W-1:0] res_raddr,
   output logic [PERM_W-1:0] res_perm
);

   // elaboration-time parameter checks
   if (N_ENT < 2) begin : g_bad_n
      $error("N_ENT must be at least 2");
   end
   if (BLK_LSB + BL_W > ADDR_W) begin : g_bad_len
      $error("block-length field does not fit in the address");
   end
   if (BL_W + 2 > BLK_LSB) begin : g_bad_field
      $error("block-length code overlaps the base field");
   end
   if (PAGE_BITS > BLK_LSB) begin : g_bad_page
      $error("page size exceeds the smallest block");
   end

   logic [N_BANKS-1:0][N_ENT-1:0]             bank_match;
   logic [N_BANKS-1:0][N_ENT-1:0][ADDR_W-1:0] bank_raddr;
   logic [N_BANKS-1:0][N_ENT-1:0][PERM_W-1:0] bank_perm;

   for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      logic [N_ENT-1:0][ADDR_W-1:0] up_q;
      logic [N_ENT-1:0][ADDR_W-1:0] lo_q;
      logic                         bank_we;

      assign bank_we = wr_en && (wr_ibank == (b == BANK_INST));

      bat_bank #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) i_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (bank_we),
         .wr_lower (wr_lower),
         .wr_idx   (wr_idx),
         .wr_data  (wr_data),
         .upper_q  (up_q),
         .lower_q  (lo_q)
      );

      for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
         bat_entry_cmp #(
            .ADDR_W   (ADDR_W),
            .BLK_LSB  (BLK_LSB),
            .BL_W     (BL_W),
            .PAGE_BITS(PAGE_BITS)
         ) i_cmp (
            .upper    (up_q[e]),
            .lower    (lo_q[e]),
            .ea       (ea),
            .user_mode(user_mode),
            .match    (bank_match[b][e]),
            .raddr    (bank_raddr[b][e]),
            .perm     (bank_perm[b][e])
         );
      end
   end

   logic              use_inst;
   logic [N_ENT-1:0]  req;
   logic [N_ENT-1:0]  grant;
   logic              any_hit;
   logic [ADDR_W-1:0] sel_raddr;
   logic [PERM_W-1:0] sel_perm;

   assign use_inst = (acc_kind == ACC_FETCH);
   assign req      = use_inst ? bank_match[BANK_INST] : bank_match[BANK_DATA];

   bat_prio #(.N(N_ENT)) i_prio (
      .req  (req),
      .grant(grant),
      .any  (any_hit)
   );

   always_comb begin
      sel_raddr = '0;
      sel_perm  = '0;
      for (int i = 0; i < N_ENT; i++) begin
         if (grant[i]) begin
            sel_raddr = sel_raddr | (use_inst ? bank_raddr[BANK_INST][i]
                                              : bank_raddr[BANK_DATA][i]);
            sel_perm  = sel_perm  | (use_inst ? bank_perm[BANK_INST][i]
                                              : bank_perm[BANK_DATA][i]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_hit   <= 1'b0;
         res_raddr <= '0;
         res_perm  <= '0;
      end else begin
         res_hit   <= any_hit;
         res_raddr <= sel_raddr;
         res_perm  <= sel_perm;
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R7
   AST_GRANT_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) == (|grant)); // R7
   AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !res_hit |-> (res_raddr == '0 && res_perm == '0)); // R8
   AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      res_raddr[PAGE_BITS-1:0] == '0); // R5
   AST_PERM_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      res_perm inside {3'b000, 3'b101, 3'b111}); // R6
   AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> $past(|req)); // R9

endmodule

// File: tb/test_blk_xlate_match.sv
module test_blk_xlate_match;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_ibank = 1'b0;
   logic        wr_lower = 1'b0;
   logic [1:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] ea = '0;
   logic [1:0]  acc_kind = 2'b00;
   logic        user_mode = 1'b0;
   logic        res_hit;
   logic [31:0] res_raddr;
   logic [2:0]  res_perm;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [31:0] m_up [2][4];
   logic [31:0] m_lo [2][4];

   always #(CLK_PERIOD/2) clk = ~clk;

   blk_xlate_match i_blk_xlate_match (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ibank(wr_ibank),
      .wr_lower(wr_lower), .wr_idx(wr_idx), .wr_data(wr_data),
      .ea(ea), .acc_kind(acc_kind), .user_mode(user_mode),
      .res_hit(res_hit), .res_raddr(res_raddr), .res_perm(res_perm)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // reference model built from the requirements
   task automatic model(input logic [31:0] a, input logic [1:0] k, input logic u,
                        output logic h, output logic [31:0] ra, output logic [2:0] p);
      int bk;
      bk = (k == 2'b10) ? 1 : 0;                         // R1
      h = 1'b0; ra = '0; p = '0;
      for (int i = 3; i >= 0; i--) begin                 // R7: lowest index overrides
         logic [31:0] up, lo, msk;
         up = m_up[bk][i];
         lo = m_lo[bk][i];
         msk = 32'hFFFE_0000 & ~({21'd0, up[12:2]} << 17); // R3
         if ((u ? up[0] : up[1]) && ((a & msk) == (up & 32'hFFFE_0000))) begin // R2 R4
            h = 1'b1;
            ra = ((lo & msk) | (a & ~msk)) & 32'hFFFF_F000; // R5
            case (lo[1:0])                                 // R6
               2'd0: p = 3'b000;
               2'd2: p = 3'b111;
               default: p = 3'b101;
            endcase
         end
      end
   endtask

   task automatic wr_reg(input bit ib, input int idx, input bit low, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_ibank = ib; wr_idx = 2'(idx); wr_lower = low; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (low) m_lo[ib][idx] = d; else m_up[ib][idx] = d;
   endtask

   task automatic look(input string tag, input logic [31:0] a, input logic [1:0] k, input logic u);
      logic h; logic [31:0] ra; logic [2:0] p;
      @(negedge clk);
      ea = a; acc_kind = k; user_mode = u;
      @(posedge clk);
      #1;
      model(a, k, u, h, ra, p);
      chk({tag, " hit"}, {31'd0, res_hit}, {31'd0, h});
      chk({tag, " raddr"}, res_raddr, ra);
      chk({tag, " perm"}, {29'd0, res_perm}, {29'd0, p});
   endtask

   task automatic t_reset;
      chk("R11 reset hit", {31'd0, res_hit}, 32'd0);
      chk("R11 reset raddr", res_raddr, 32'd0);
      chk("R11 reset perm", {29'd0, res_perm}, 32'd0);
      look("R11 empty lookup", 32'h1234_5678, 2'b00, 1'b0);
   endtask

   task automatic t_basic;
      wr_reg(0, 0, 0, 32'h1000_0002);   // supervisor valid, 128 KiB
      wr_reg(0, 0, 1, 32'h8000_0002);   // code 2
      look("R4 sup load", 32'h1001_2345, 2'b00, 1'b0);
      chk("R5 literal raddr", res_raddr, 32'h8001_2000);
      chk("R6 literal rwx", {29'd0, res_perm}, 32'd7);
      look("R2 user blocked", 32'h1001_2345, 2'b00, 1'b1);
      chk("R2 literal miss", {31'd0, res_hit}, 32'd0);
      look("R4 outside block", 32'h1002_0000, 2'b00, 1'b0);
      look("R1 store data bank", 32'h1000_0010, 2'b01, 1'b0);
      look("R1 fetch misses inst", 32'h1001_2345, 2'b10, 1'b0);
      chk("R8 literal miss raddr", res_raddr, 32'd0);
   endtask

   task automatic t_inst_bank;
      wr_reg(1, 0, 0, 32'h1000_0001);   // user valid only
      wr_reg(1, 0, 1, 32'hC000_0003);   // code 3
      look("R1 user fetch", 32'h1000_4ABC, 2'b10, 1'b1);
      chk("R6 literal code3", {29'd0, res_perm}, 32'd5);
      look("R2 sup fetch blocked", 32'h1000_4ABC, 2'b10, 1'b0);
      look("R1 user load no inst", 32'h1000_4ABC, 2'b00, 1'b1);
      look("R1 kind11 data bank", 32'h1000_4ABC, 2'b11, 1'b0);
   endtask

   task automatic t_length;
      wr_reg(0, 1, 0, 32'h2000_1FFF);   // max length, both valid
      wr_reg(0, 1, 1, 32'h4000_0001);
      look("R3 wide block", 32'h2ABC_D123, 2'b00, 1'b1);
      chk("R3 literal raddr", res_raddr, 32'h4ABC_D000);
      look("R3 beyond wide block", 32'h3000_0000, 2'b00, 1'b0);
   endtask

   task automatic t_priority;
      wr_reg(0, 3, 0, 32'h2000_0003);
      wr_reg(0, 3, 1, 32'h6000_0002);
      look("R7 lower index wins", 32'h2000_1000, 2'b00, 1'b0);
      chk("R7 literal raddr", res_raddr, 32'h4000_1000);
      wr_reg(0, 1, 0, 32'h0000_0000);   // disable entry 1
      look("R10 rewrite upper", 32'h2000_1000, 2'b00, 1'b0);
      chk("R10 literal next entry", res_raddr, 32'h6000_1000);
      look("R10 entry 0 untouched", 32'h1001_2345, 2'b00, 1'b0);
   endtask

   task automatic t_prot_zero;
      wr_reg(0, 2, 0, 32'h5000_0002);
      wr_reg(0, 2, 1, 32'h7000_0000);
      look("R6 code 0 hit", 32'h5000_0800, 2'b01, 1'b0);
      chk("R6 literal none", {29'd0, res_perm}, 32'd0);
   endtask

   task automatic t_latency;
      look("R9 first", 32'h1001_2345, 2'b00, 1'b0);
      @(negedge clk);
      ea = 32'h5000_0800;
      #1;
      chk("R9 holds before edge", res_raddr, 32'h8001_2000);
      @(posedge clk);
      #1;
      chk("R9 updates after edge", res_raddr, 32'h7000_0000);
   endtask

   initial begin
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < 4; i++) begin
            m_up[b][i] = '0;
            m_lo[b][i] = '0;
         end
      repeat (4) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_basic();
      t_inst_bank();
      t_length();
      t_priority();
      t_prot_zero();
      t_latency();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule